// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is the byte-level control core of an SPI flash slave. A bit shifter outside the block hands it each received byte with a one-cycle valid strobe. The block returns the byte to be shifted out on the next transfer. While chip select is low, the first byte of a transaction is taken as an opcode. Depending on the opcode, the block then does one of the following: gathers address, mode and dummy bytes; streams array data; issues program and erase requests to the storage engine; or answers status and identification queries. It also keeps the write-enable latch.

The number of bytes that follow an opcode depends on the opcode. For the dual and quad I/O reads it also depends on the configured manufacturer code. The identification reply grows by two bytes when a nonzero extension code is configured. Array reads use a combinational lookup: the block presents the current address and returns the data it is given. Programs and erases are issued as single-cycle requests. Protection violations and unrecognised opcodes raise single-cycle flags.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: After reset, tx_byte_o is 0x00, no request or flag is raised, and the write-enable latch is clear.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 answers one byte: bit 1 holds the latch and every other bit is 0. The block then returns to opcode decoding.
- R3: Opcode 0x9F answers with MFR_ID, then DEV_ID[15:8], then DEV_ID[7:0]. When EXT_ID is nonzero, EXT_ID[15:8] and EXT_ID[7:0] follow. After the last byte, the next byte is decoded as an opcode.
- R4: Opcodes 0x03, 0x02, 0x32, 0xA2, 0x20, 0x52 and 0xD8 take 3 following bytes. Opcodes 0x0B, 0x3B and 0x6B take 4. The address is the first three of these bytes, most significant first.
- R5: Opcode 0xBB takes 4 following bytes when MFR_ID is 0xEF or 0x01, and 5 otherwise. Opcode 0xEB takes 6 or 8 bytes under the same rule.
- R6: After a read opcode's bytes, rd_addr_o holds the collected address. tx_byte_o equals rd_data_i. Each received byte advances rd_addr_o by one, wrapping at 2^ADDR_W.
- R7: After a program opcode's bytes, each received byte raises arr_req_o with arr_op_o=1, the current address and the byte as data. The address then advances. The request is issued even when the latch is clear, but err_wp_o also pulses in that case.
- R8: When the last byte of 0x20, 0x52 or 0xD8 arrives and the latch is set, arr_req_o pulses with arr_op_o 2, 3 or 4 respectively and the collected address. When the latch is clear, err_wp_o pulses and no request is issued.
- R9: Opcode 0xC7 raises arr_req_o with arr_op_o=5 and address 0 on the opcode byte itself when the latch is set. Otherwise it pulses err_wp_o.
- R10: Opcode 0x01 with the latch set takes one following byte and then clears the latch. With the latch clear, it is ignored and the next byte is decoded as an opcode.
- R11: An unassigned opcode pulses err_unknown_o and changes nothing else. Opcode 0x00 does nothing.
- R12: While cs_ni is high, received bytes are ignored and the block returns to opcode decoding. Raising cs_ni mid-command abandons the command.
- R13: tx_byte_o is 0x00 while the block awaits an opcode, collects bytes or programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a byte was exchanged |
| rx_byte_i | input | 8 | Byte received from the host |
| tx_byte_o | output | 8 | Byte to present on the next exchange |
| rd_addr_o | output | ADDR_W | Current array read address |
| rd_data_i | input | 8 | Array data at rd_addr_o |
| arr_req_o | output | 1 | Program or erase request strobe |
| arr_op_o | output | 3 | 1 program, 2 small erase, 3 mid erase, 4 block erase, 5 chip erase |
| arr_addr_o | output | ADDR_W | Request address |
| arr_wdata_o | output | 8 | Program data |
| err_wp_o | output | 1 | Write-protect violation strobe |
| err_unknown_o | output | 1 | Unassigned opcode strobe |

## Verification
The hardest cases to reach are the ones where the same byte value means different things depending on history. Examples are a write-enable opcode arriving just after a status-write opcode that was refused, and a status opcode arriving just after chip select was raised mid-read. The stimulus builds these sequences on purpose and checks the decoded result against a behavioural model. The byte count that depends on the manufacturer code cannot be reached with one configuration. A second instance with the alternate code is therefore driven from the same byte bus. Its read data and identification bytes show exactly where each collection phase ends.

// File: rtl/spi_fcs_pkg.sv
package spi_fcs_pkg;

  localparam int unsigned CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLLECT = 3'd1,
    ST_PROG    = 3'd2,
    ST_READ    = 3'd3,
    ST_RESP    = 3'd4
  } fcs_state_e;

  typedef enum logic [2:0] {
    AOP_NONE   = 3'd0,
    AOP_PROG   = 3'd1,
    AOP_ER4K   = 3'd2,
    AOP_ER32K  = 3'd3,
    AOP_ERBLK  = 3'd4,
    AOP_ERCHIP = 3'd5
  } arr_op_e;

  typedef enum logic [3:0] {
    CL_NOP, CL_WEN, CL_WDIS, CL_STAT, CL_IDENT, CL_WSTAT,
    CL_PROG, CL_READ, CL_ER4K, CL_ER32K, CL_ERBLK, CL_ERCHIP, CL_UNK
  } op_class_e;

  localparam logic [7:0] OPC_NOP        = 8'h00;
  localparam logic [7:0] OPC_WR_STATUS  = 8'h01;
  localparam logic [7:0] OPC_PROG_X1    = 8'h02;
  localparam logic [7:0] OPC_READ_SLOW  = 8'h03;
  localparam logic [7:0] OPC_WR_DISABLE = 8'h04;
  localparam logic [7:0] OPC_RD_STATUS  = 8'h05;
  localparam logic [7:0] OPC_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OPC_READ_FAST  = 8'h0B;
  localparam logic [7:0] OPC_ERASE_SML  = 8'h20;
  localparam logic [7:0] OPC_PROG_X4    = 8'h32;
  localparam logic [7:0] OPC_READ_2OUT  = 8'h3B;
  localparam logic [7:0] OPC_ERASE_MID  = 8'h52;
  localparam logic [7:0] OPC_READ_4OUT  = 8'h6B;
  localparam logic [7:0] OPC_IDENT      = 8'h9F;
  localparam logic [7:0] OPC_PROG_X2    = 8'hA2;
  localparam logic [7:0] OPC_READ_2IO   = 8'hBB;
  localparam logic [7:0] OPC_ERASE_ALL  = 8'hC7;
  localparam logic [7:0] OPC_ERASE_BLK  = 8'hD8;
  localparam logic [7:0] OPC_READ_4IO   = 8'hEB;

  function automatic arr_op_e erase_op(op_class_e c);
    case (c)
      CL_ER4K:  return AOP_ER4K;
      CL_ER32K: return AOP_ER32K;
      CL_ERBLK: return AOP_ERBLK;
      default:  return AOP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fcs_op_decode.sv
module fcs_op_decode
  import spi_fcs_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h20
) (
  input  logic [7:0]       opc_i,
  output op_class_e        cls_o,
  output logic [CNT_W-1:0] need_o
);

  logic [CNT_W-1:0] dual_io_need;
  logic [CNT_W-1:0] quad_io_need;

  // the wide-I/O mode/dummy length depends on the manufacturer code
  generate
    if (MFR_ID == 8'hEF || MFR_ID == 8'h01) begin : g_short_io
      assign dual_io_need = CNT_W'(4);
      assign quad_io_need = CNT_W'(6);
    end else begin : g_long_io
      assign dual_io_need = CNT_W'(5);
      assign quad_io_need = CNT_W'(8);
    end
  endgenerate

  always_comb begin
    cls_o  = CL_UNK;
    need_o = '0;
    case (opc_i)
      OPC_NOP:        cls_o = CL_NOP;
      OPC_WR_ENABLE:  cls_o = CL_WEN;
      OPC_WR_DISABLE: cls_o = CL_WDIS;
      OPC_RD_STATUS:  cls_o = CL_STAT;
      OPC_IDENT:      cls_o = CL_IDENT;
      OPC_ERASE_ALL:  cls_o = CL_ERCHIP;
      OPC_WR_STATUS: begin cls_o = CL_WSTAT; need_o = CNT_W'(1); end
      OPC_PROG_X1, OPC_PROG_X2, OPC_PROG_X4: begin
        cls_o = CL_PROG; need_o = CNT_W'(3);
      end
      OPC_READ_SLOW: begin cls_o = CL_READ; need_o = CNT_W'(3); end
      OPC_READ_FAST, OPC_READ_2OUT, OPC_READ_4OUT: begin
        cls_o = CL_READ; need_o = CNT_W'(4);
      end
      OPC_READ_2IO:  begin cls_o = CL_READ;  need_o = dual_io_need; end
      OPC_READ_4IO:  begin cls_o = CL_READ;  need_o = quad_io_need; end
      OPC_ERASE_SML: begin cls_o = CL_ER4K;  need_o = CNT_W'(3); end
      OPC_ERASE_MID: begin cls_o = CL_ER32K; need_o = CNT_W'(3); end
      OPC_ERASE_BLK: begin cls_o = CL_ERBLK; need_o = CNT_W'(3); end
      default: ;
    endcase
  end

endmodule

// File: rtl/fcs_resp_rom.sv
module fcs_resp_rom
  import spi_fcs_pkg::*;
#(
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [15:0] DEV_ID = 16'hBB16,
  parameter logic [15:0] EXT_ID = 16'h0000
) (
  input  logic [CNT_W-1:0] idx_i,
  input  logic             is_id_i,
  input  logic             wen_i,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] len_o
);

  localparam int unsigned ID_LEN = (EXT_ID != 16'h0000) ? 5 : 3;

  logic [7:0] id_byte;

  always_comb begin
    case (idx_i)
      CNT_W'(0): id_byte = MFR_ID;
      CNT_W'(1): id_byte = DEV_ID[15:8];
      CNT_W'(2): id_byte = DEV_ID[7:0];
      CNT_W'(3): id_byte = EXT_ID[15:8];
      CNT_W'(4): id_byte = EXT_ID[7:0];
      default:   id_byte = 8'h00;
    endcase
  end

  assign byte_o = is_id_i ? id_byte : {6'b0, wen_i, 1'b0};
  assign len_o  = is_id_i ? CNT_W'(ID_LEN) : CNT_W'(1);

endmodule

// File: rtl/spi_flash_cmd_seq.sv
module spi_flash_cmd_seq
  import spi_fcs_pkg::*;
#(
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [15:0] DEV_ID = 16'hBB16,
  parameter logic [15:0] EXT_ID = 16'h0000,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        tx_byte_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              arr_req_o,
  output logic [2:0]        arr_op_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_wdata_o,
  output logic              err_wp_o,
  output logic              err_unknown_o
);

  localparam int unsigned ABYTES = 3;

  fcs_state_e       state_q;
  op_class_e        cls_q;
  op_class_e        dec_cls;
  logic [CNT_W-1:0] dec_need;
  logic [CNT_W-1:0] need_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] resp_len;
  logic [7:0]       resp_byte;
  logic [7:0]       abuf_q [ABYTES];
  logic [23:0]      fin_addr;
  logic [ADDR_W-1:0] addr_q;
  logic             wen_q;
  logic             is_id_q;
  logic             req_q, wp_q, unk_q;
  arr_op_e          op_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [7:0]       wdata_q;
  logic             take;

  fcs_op_decode #(.MFR_ID(MFR_ID)) u_dec (
    .opc_i  (rx_byte_i),
    .cls_o  (dec_cls),
    .need_o (dec_need)
  );

  fcs_resp_rom #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .EXT_ID(EXT_ID)) u_resp (
    .idx_i   (cnt_q),
    .is_id_i (is_id_q),
    .wen_i   (wen_q),
    .byte_o  (resp_byte),
    .len_o   (resp_len)
  );

  assign take    = rx_valid_i && !cs_ni;
  assign cnt_nxt = cnt_q + 1'b1;
  // third address byte may be the one arriving now
  assign fin_addr = {abuf_q[0], abuf_q[1], (cnt_q == CNT_W'(2)) ? rx_byte_i : abuf_q[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cls_q      <= CL_NOP;
      need_q     <= '0;
      cnt_q      <= '0;
      for (int i = 0; i < ABYTES; i++) abuf_q[i] <= '0;
      addr_q     <= '0;
      wen_q      <= 1'b0;
      is_id_q    <= 1'b0;
      req_q      <= 1'b0;
      wp_q       <= 1'b0;
      unk_q      <= 1'b0;
      op_q       <= AOP_NONE;
      req_addr_q <= '0;
      wdata_q    <= '0;
    end else begin
      req_q <= 1'b0;
      wp_q  <= 1'b0;
      unk_q <= 1'b0;
      if (cs_ni) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (take) begin
        case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            case (dec_cls)
              CL_NOP:  ;
              CL_WEN:  wen_q <= 1'b1;
              CL_WDIS: wen_q <= 1'b0;
              CL_STAT: begin state_q <= ST_RESP; is_id_q <= 1'b0; end
              CL_IDENT: begin state_q <= ST_RESP; is_id_q <= 1'b1; end
              CL_WSTAT: begin
                if (wen_q) begin
                  state_q <= ST_COLLECT;
                  cls_q   <= dec_cls;
                  need_q  <= dec_need;
                end
              end
              CL_ERCHIP: begin
                if (wen_q) begin
                  req_q      <= 1'b1;
                  op_q       <= AOP_ERCHIP;
                  req_addr_q <= '0;
                end else begin
                  wp_q <= 1'b1;
                end
              end
              CL_UNK: unk_q <= 1'b1;
              default: begin
                state_q <= ST_COLLECT;
                cls_q   <= dec_cls;
                need_q  <= dec_need;
              end
            endcase
          end
          ST_COLLECT: begin
            if (cnt_q < CNT_W'(ABYTES)) abuf_q[cnt_q[1:0]] <= rx_byte_i;
            cnt_q <= cnt_nxt;
            if (cnt_nxt == need_q) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
              if (need_q >= CNT_W'(ABYTES)) addr_q <= fin_addr[ADDR_W-1:0];
              case (cls_q)
                CL_PROG: state_q <= ST_PROG;
                CL_READ: state_q <= ST_READ;
                CL_ER4K, CL_ER32K, CL_ERBLK: begin
                  if (wen_q) begin
                    req_q      <= 1'b1;
                    op_q       <= erase_op(cls_q);
                    req_addr_q <= fin_addr[ADDR_W-1:0];
                  end else begin
                    wp_q <= 1'b1;
                  end
                end
                CL_WSTAT: wen_q <= 1'b0;
                default: ;
              endcase
            end
          end
          ST_PROG: begin
            req_q      <= 1'b1;
            op_q       <= AOP_PROG;
            req_addr_q <= addr_q;
            wdata_q    <= rx_byte_i;
            wp_q       <= !wen_q;
            addr_q     <= addr_q + 1'b1;
          end
          ST_READ: addr_q <= addr_q + 1'b1;
          ST_RESP: begin
            if (cnt_nxt == resp_len) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_nxt;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_READ: tx_byte_o = rd_data_i;
      ST_RESP: tx_byte_o = resp_byte;
      default: tx_byte_o = 8'h00;
    endcase
  end

  assign rd_addr_o     = addr_q;
  assign arr_req_o     = req_q;
  assign arr_op_o      = op_q;
  assign arr_addr_o    = req_addr_q;
  assign arr_wdata_o   = wdata_q;
  assign err_wp_o      = wp_q;
  assign err_unknown_o = unk_q;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import spi_fcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rx_valid_i,
  input logic [7:0]        tx_byte_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              arr_req_o,
  input logic [2:0]        arr_op_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              err_wp_o,
  input logic              err_unknown_o,
  input fcs_state_e        state_i
);

  assert_req_from_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_o |-> $past(rx_valid_i && !cs_ni));

  assert_wp_blocks_erase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_wp_o |-> !(arr_req_o && arr_op_o != 3'(AOP_PROG)));

  assert_chip_at_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_o && arr_op_o == 3'(AOP_ERCHIP)) |-> arr_addr_o == '0);

  assert_err_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_unknown_o |-> !(arr_req_o || err_wp_o));

  assert_deselect_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> (tx_byte_o == 8'h00 && !arr_req_o && !err_wp_o && !err_unknown_o));

  assert_read_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_valid_i && !cs_ni && state_i == ST_READ) |->
      rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));

endmodule

bind spi_flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W)) u_fcs_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_ni         (cs_ni),
  .rx_valid_i    (rx_valid_i),
  .tx_byte_o     (tx_byte_o),
  .rd_addr_o     (rd_addr_o),
  .arr_req_o     (arr_req_o),
  .arr_op_o      (arr_op_o),
  .arr_addr_o    (arr_addr_o),
  .err_wp_o      (err_wp_o),
  .err_unknown_o (err_unknown_o),
  .state_i       (state_q)
);

// File: tb/test_spi_flash_cmd_seq.sv
module test_spi_flash_cmd_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_a = 1'b1;
  logic cs_b = 1'b1;
  logic rxv = 1'b0;
  logic [7:0] rxb = 8'h00;

  always #10 clk = ~clk;

  logic [7:0]  tx_a, tx_b, rd_a, wd_a, wd_b;
  logic [23:0] rda_a, rda_b, aa_a, aa_b;
  logic        req_a, req_b, wp_a, wp_b, unk_a, unk_b;
  logic [2:0]  op_a, op_b;
  logic [7:0]  mem [4096];

  assign rd_a = mem[rda_a[11:0]];

  spi_flash_cmd_seq i_spi_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_a), .rx_valid_i(rxv), .rx_byte_i(rxb),
    .tx_byte_o(tx_a), .rd_addr_o(rda_a), .rd_data_i(rd_a),
    .arr_req_o(req_a), .arr_op_o(op_a), .arr_addr_o(aa_a), .arr_wdata_o(wd_a),
    .err_wp_o(wp_a), .err_unknown_o(unk_a));

  spi_flash_cmd_seq #(.MFR_ID(8'hEF), .DEV_ID(16'h4016), .EXT_ID(16'h4D00)) i_spi_flash_cmd_seq_alt (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_b), .rx_valid_i(rxv), .rx_byte_i(rxb),
    .tx_byte_o(tx_b), .rd_addr_o(rda_b), .rd_data_i(rda_b[7:0]),
    .arr_req_o(req_b), .arr_op_o(op_b), .arr_addr_o(aa_b), .arr_wdata_o(wd_b),
    .err_wp_o(wp_b), .err_unknown_o(unk_b));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  // behavioural reference model of instance A (MFR 0x20, ID 20 BB 16, no extension)
  int          ms = 0;        // 0 opcode, 1 gather, 2 program, 3 read, 4 reply
  bit          mwe = 0;
  int          mneed = 0;
  logic [7:0]  mop = 0;
  logic [7:0]  col [$];
  logic [7:0]  rq [$];
  logic [23:0] maddr = 0;

  task automatic send(input logic [7:0] b);
    bit ereq = 0, ewp = 0, eunk = 0;
    int eop = 0;
    logic [23:0] ea = '0;
    logic [7:0] ewd = '0;
    string tag = "R13";
    @(negedge clk);
    if (!cs_a) begin
      if (ms == 3) begin
        chk("R6 read data", tx_a, mem[maddr[11:0]]);
        chk("R6 read address", rda_a, maddr);
      end else if (ms == 4) chk("R3 reply byte", tx_a, rq[0]);
      else chk("R13 quiet tx", tx_a, 0);
      case (ms)
        0: begin
          case (b)
            8'h00: tag = "R11";
            8'h06: begin mwe = 1; tag = "R2"; end
            8'h04: begin mwe = 0; tag = "R2"; end
            8'h05: begin rq.push_back({6'b0, mwe, 1'b0}); ms = 4; tag = "R2"; end
            8'h9F: begin rq = '{8'h20, 8'hBB, 8'h16}; ms = 4; tag = "R3"; end
            8'h01: begin
              tag = "R10";
              if (mwe) begin mop = b; mneed = 1; col.delete(); ms = 1; end
            end
            8'h02, 8'h32, 8'hA2, 8'h03, 8'h20, 8'h52, 8'hD8: begin
              mop = b; mneed = 3; col.delete(); ms = 1; tag = "R4";
            end
            8'h0B, 8'h3B, 8'h6B: begin mop = b; mneed = 4; col.delete(); ms = 1; tag = "R4"; end
            8'hBB: begin mop = b; mneed = 5; col.delete(); ms = 1; tag = "R5"; end
            8'hEB: begin mop = b; mneed = 8; col.delete(); ms = 1; tag = "R5"; end
            8'hC7: begin
              tag = "R9";
              if (mwe) begin ereq = 1; eop = 5; ea = 0; end else ewp = 1;
            end
            default: begin eunk = 1; tag = "R11"; end
          endcase
        end
        1: begin
          col.push_back(b);
          tag = "R4";
          if (col.size() == mneed) begin
            ms = 0;
            if (mneed >= 3) maddr = {col[0], col[1], col[2]};
            case (mop)
              8'h02, 8'h32, 8'hA2: ms = 2;
              8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB: ms = 3;
              8'h20, 8'h52, 8'hD8: begin
                tag = "R8";
                if (mwe) begin
                  ereq = 1; ea = maddr;
                  eop = (mop == 8'h20) ? 2 : (mop == 8'h52) ? 3 : 4;
                end else ewp = 1;
              end
              8'h01: begin mwe = 0; tag = "R10"; end
              default: ;
            endcase
          end
        end
        2: begin
          tag = "R7"; ereq = 1; eop = 1; ea = maddr; ewd = b; ewp = !mwe;
          maddr = maddr + 1;
        end
        3: begin tag = "R6"; maddr = maddr + 1; end
        default: begin
          tag = "R3";
          void'(rq.pop_front());
          if (rq.size() == 0) ms = 0;
        end
      endcase
    end else begin
      chk("R12 tx while deselected", tx_a, 0);
      tag = "R12";
    end
    rxb = b;
    rxv = 1'b1;
    @(negedge clk);
    rxv = 1'b0;
    chk({tag, " request strobe"}, req_a, ereq);
    if (ereq) begin
      chk({tag, " request op"}, op_a, eop);
      chk({tag, " request address"}, aa_a, ea);
      if (eop == 1) chk({tag, " program data"}, wd_a, ewd);
    end
    chk({tag, " protect flag"}, wp_a, ewp);
    chk({tag, " unknown flag"}, unk_a, eunk);
    if (ereq) begin
      if (eop == 1) mem[ea[11:0]] = mem[ea[11:0]] & ewd;
      else for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    end
  endtask

  task automatic set_cs_a(input logic v);
    @(negedge clk);
    cs_a = v;
    if (v) begin ms = 0; col.delete(); rq.delete(); end
  endtask

  task automatic cmd(input logic [7:0] b0, input int n, input logic [7:0] fill);
    set_cs_a(1'b0);
    send(b0);
    for (int i = 0; i < n; i++) send(fill);
    set_cs_a(1'b1);
  endtask

  task automatic send_seq(input logic [7:0] s [$]);
    set_cs_a(1'b0);
    foreach (s[i]) send(s[i]);
    set_cs_a(1'b1);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx at reset", tx_a, 0);
    chk("R1 request at reset", req_a, 0);
    chk("R1 flags at reset", {wp_a, unk_a}, 0);
    rst_n = 1'b1;
    cmd(8'h05, 1, 8'h00);                       // R1 latch clear
    cmd(8'h06, 0, 8'h00);                       // R2
    cmd(8'h05, 2, 8'h00);                       // R2 reply then decode 00
    cmd(8'h9F, 4, 8'h00);                       // R3
    send_seq('{8'h02, 8'h00, 8'h00, 8'h10, 8'hAA, 8'h55, 8'hF0}); // R7
    send_seq('{8'h03, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00}); // R4 R6
    send_seq('{8'h0B, 8'h00, 8'h00, 8'h11, 8'h99, 8'h00, 8'h00}); // R4
    send_seq('{8'h3B, 8'h00, 8'h00, 8'h10, 8'h99, 8'h00});
    send_seq('{8'h6B, 8'h00, 8'h00, 8'h12, 8'h99, 8'h00});
    send_seq('{8'hBB, 8'h00, 8'h00, 8'h10, 8'h77, 8'h77, 8'h00, 8'h00}); // R5 long form
    send_seq('{8'hEB, 8'h00, 8'h00, 8'h11, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h00, 8'h00});
    send_seq('{8'h03, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00}); // R6 wrap
    send_seq('{8'h32, 8'h00, 8'h0F, 8'hFF, 8'h3C, 8'hC3});        // R7 quad program
    send_seq('{8'h20, 8'h00, 8'h01, 8'h00});                      // R8
    send_seq('{8'h52, 8'h12, 8'h34, 8'h56});
    send_seq('{8'hD8, 8'hAB, 8'hCD, 8'hEF});
    cmd(8'h04, 0, 8'h00);                                         // R2 clear
    send_seq('{8'h20, 8'h00, 8'h00, 8'h00});                      // R8 protected
    send_seq('{8'hA2, 8'h00, 8'h00, 8'h20, 8'h12});               // R7 protected
    cmd(8'hC7, 0, 8'h00);                                         // R9 protected
    cmd(8'h06, 0, 8'h00);
    cmd(8'hC7, 0, 8'h00);                                         // R9
    send_seq('{8'h01, 8'h55, 8'h05, 8'h00});                      // R10 clears latch
    send_seq('{8'h01, 8'h06, 8'h05, 8'h00});                      // R10 ignored
    send_seq('{8'hFF, 8'h00, 8'h05, 8'h00});                      // R11
    send_seq('{8'h5A, 8'h04, 8'h05, 8'h00});                      // R11 then disable
    // R12 abort mid-read and ignore bytes while deselected
    send_seq('{8'h03, 8'h00});
    send(8'h06);
    send_seq('{8'h05, 8'h00});
    // R5 short form on the alternate configuration
    @(negedge clk); cs_b = 1'b0;
    send(8'hBB); send(8'h00); send(8'h00); send(8'h10);
    chk("R5 dual-io still gathering", tx_b, 0);
    send(8'h77);
    chk("R5 dual-io read after 4 bytes", tx_b, 8'h10);
    @(negedge clk); cs_b = 1'b1;
    @(negedge clk); cs_b = 1'b0;
    send(8'hEB);
    for (int i = 0; i < 5; i++) send(i == 2 ? 8'h20 : 8'h00);
    chk("R5 quad-io still gathering", tx_b, 0);
    send(8'h00);
    chk("R5 quad-io read after 6 bytes", tx_b, 8'h20);
    @(negedge clk); cs_b = 1'b1;
    @(negedge clk); cs_b = 1'b0;
    send(8'h9F);
    chk("R3 ext id byte 0", tx_b, 8'hEF); send(8'h00);
    chk("R3 ext id byte 1", tx_b, 8'h40); send(8'h00);
    chk("R3 ext id byte 2", tx_b, 8'h16); send(8'h00);
    chk("R3 ext id byte 3", tx_b, 8'h4D); send(8'h00);
    chk("R3 ext id byte 4", tx_b, 8'h00); send(8'h00);
    chk("R3 idle after ext id", tx_b, 8'h00);
    chk("R11 no error on alt", unk_b, 0);
    @(negedge clk); cs_b = 1'b1;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule